// File: doc/BRIEF.md
# Dual-Compare 8-bit Timer

This block is an 8-bit up/down counter with two compare channels, meant to sit beside a prescaler and a port multiplexer in a microcontroller-class subsystem. One of four count sources advances the counter: a stopped setting, every core clock, a one-cycle tick from an external prescaler, or an edge on an event pin. An event pin that changes asynchronously is synchronised before its edges are counted.

Four waveform modes are available: free-running, clear-on-compare-A, single-slope PWM and dual-slope PWM. Each compare channel drives one waveform output and keeps a sticky match flag. A shared overflow flag records wrap or bottom events. Each flag is cleared by writing a one to its bit. In the two PWM modes, compare values go through a shadow register and take effect at the top of the count. In the other two modes they take effect on the next clock. Force strobes let software apply a channel's compare action without a counter match, but only outside the PWM modes.

Top module: `dual_cmp_timer`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears the count, both wave outputs, all three flags and both compare values.
- R2: clk_sel selects the count source: 00 holds the count, 01 counts every clock, 10 counts on cycles where pre_tick is high, 11 counts edges of ext_pin after a two-flop synchroniser. The edge is rising when ext_rise is 1 and falling when ext_rise is 0. The pin is counted whatever else drives it.
- R3: In mode 00 (free-running) the count increments by one per count event and wraps from 255 to 0. The wrap sets the overflow flag (flag_clr bit 0 / ovf_flag).
- R4: In mode 01 (clear on compare A) the count returns to 0 on the event after it equals compare A. The period is therefore compare A + 1 events, and the toggle action gives a square wave with 50% duty.
- R5: In modes 00 and 01 a compare write reaches the active compare value on the next clock. In modes 10 and 11 the write lands in a shadow register, which is copied to the active value on the count event taken at 255.
- R6: A channel's match flag sets on the count event taken while the count equals that channel's active compare value. Flag A is flag_clr bit 1 and flag B is flag_clr bit 2.
- R7: In modes 00 and 01 a match applies the channel action: 00 hold, 01 toggle, 10 drive low, 11 drive high.
- R8: In mode 10 (single slope 0..255) action 10 drives the wave high on the event at 255 and low on a match. Action 11 does the opposite. The event at 255 takes priority, so with action 10 the wave is high for compare+1 of every 256 events and constantly high for compare 255.
- R9: In mode 11 (dual slope) the count rises 0..255 and falls back to 0, a period of 510 events. The overflow flag sets only on the step from 1 to 0.
- R10: In mode 11, action 10 drives the wave low on a rising-slope match and high on a falling-slope match, and action 11 does the reverse. For compare values 1..254, action 10 gives 2*compare high events per period.
- R11: force_a / force_b apply the channel action at once in modes 00 and 01 without setting a flag or moving the count. In modes 10 and 11 they have no effect.
- R12: A flag bit stays set until a one is written to its flag_clr bit. A set event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Count source select |
| pre_tick | input | 1 | One-cycle tick from an external prescaler |
| ext_pin | input | 1 | Asynchronous event pin |
| ext_rise | input | 1 | 1: count rising edges of ext_pin, 0: falling |
| mode | input | 2 | Waveform mode |
| act_a | input | 2 | Compare action, channel A |
| act_b | input | 2 | Compare action, channel B |
| cmp_a_wr | input | 1 | Write strobe for compare A |
| cmp_b_wr | input | 1 | Write strobe for compare B |
| cmp_wdata | input | 8 | Compare write data |
| force_a | input | 1 | Force strobe, channel A |
| force_b | input | 1 | Force strobe, channel B |
| flag_clr | input | 3 | Write-one-to-clear: bit0 overflow, bit1 match A, bit2 match B |
| count | output | 8 | Counter value |
| wave_a | output | 1 | Waveform output, channel A |
| wave_b | output | 1 | Waveform output, channel B |
| ovf_flag | output | 1 | Overflow / bottom flag |
| match_a_flag | output | 1 | Match flag, channel A |
| match_b_flag | output | 1 | Match flag, channel B |

## Verification
The hardest case to reach is a compare write that lands in the middle of a PWM period. The shadow copy must hold off the new value until the count reaches 255, while the same write outside PWM must act at once. The bench reaches this case by following the count at the ports. It issues the write at a chosen count value and then samples the wave at counts on both sides of the old and new compare values, in that period and the next. The dual-slope mode is handled the same way: the bench locks onto the single bottom sample of the period and checks the high-sample total and the overflow timing over a full 510-event window.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the dual-compare timer.
// Assumes: 2-bit fields for mode, count source and compare action.
package dct_pkg;
    typedef enum logic [1:0] {
        WM_FREE  = 2'b00,
        WM_CLRA  = 2'b01,
        WM_SLOPE = 2'b10,
        WM_DUAL  = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        CS_HOLD = 2'b00,
        CS_CORE = 2'b01,
        CS_PRE  = 2'b10,
        CS_PIN  = 2'b11
    } cnt_src_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } cmp_act_e;
endpackage

// File: rtl/dct_tick_sel.sv
`timescale 1ns/1ps
// Count-source selector: produces one count-enable pulse per event.
// Assumes: pre_tick is synchronous to clk; ext_pin is asynchronous and
// changes no faster than once every SYNC_STAGES+1 clocks.
module dct_tick_sel
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       pre_tick,
    input  logic       ext_pin,
    input  logic       ext_rise,
    output logic       tick
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] pin_sh;
    logic            pin_now;
    logic            pin_old;
    logic            rise_evt;
    logic            fall_evt;

    // Synchronise the pin and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_sh <= '0;
        else        pin_sh <= {pin_sh[SH_W-2:0], ext_pin};
    end

    // Edge detection on the synchronised pin.
    always_comb begin
        pin_now  = pin_sh[SYNC_STAGES-1];
        pin_old  = pin_sh[SYNC_STAGES];
        rise_evt = pin_now & ~pin_old;
        fall_evt = ~pin_now & pin_old;
    end

    // Source multiplexer.
    always_comb begin
        unique case (cnt_src_e'(src))
            CS_HOLD: tick = 1'b0;
            CS_CORE: tick = 1'b1;
            CS_PRE:  tick = pre_tick;
            CS_PIN:  tick = ext_rise ? rise_evt : fall_evt;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/dct_counter.sv
`timescale 1ns/1ps
// Counter core: free-running, clear-on-compare, single- and dual-slope
// counting, plus the overflow flag.
// Assumes: tick is a single-cycle enable; ctc_top is the active compare A.
module dct_counter
    import dct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   mode,
    input  logic [W-1:0] ctc_top,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         cnt_up,
    output logic         at_top,
    output logic         ovf_flag
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] BOTV = '0;
    localparam logic [W-1:0] ONEV = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_nxt;
    logic         ovf_set;
    wave_mode_e   wm;

    // Next count value and overflow event for the selected mode.
    always_comb begin
        wm      = wave_mode_e'(mode);
        at_top  = (cnt == MAXV);
        cnt_nxt = cnt + ONEV;
        ovf_set = 1'b0;
        unique case (wm)
            WM_FREE, WM_SLOPE: begin
                ovf_set = at_top;
            end
            WM_CLRA: begin
                if (cnt == ctc_top) cnt_nxt = BOTV;
                ovf_set = at_top;
            end
            WM_DUAL: begin
                if (cnt_up) cnt_nxt = at_top ? (cnt - ONEV) : (cnt + ONEV);
                else        cnt_nxt = (cnt == BOTV) ? (cnt + ONEV) : (cnt - ONEV);
                ovf_set = !cnt_up && (cnt == ONEV);
            end
            default: ovf_set = 1'b0;
        endcase
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= BOTV;
        else if (tick) cnt <= cnt_nxt;
    end

    // Slope direction; forced upward outside dual-slope mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_up <= 1'b1;
        else if (wm != WM_DUAL)      cnt_up <= 1'b1;
        else if (tick) begin
            if (cnt_up && at_top)            cnt_up <= 1'b0;
            else if (!cnt_up && cnt == BOTV) cnt_up <= 1'b1;
        end
    end

    // Sticky overflow flag, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf_flag <= 1'b0;
        else if (tick && ovf_set) ovf_flag <= 1'b1;
        else if (ovf_clr)        ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/dct_cmp_chan.sv
`timescale 1ns/1ps
// One compare channel: shadow and active compare value, match flag and
// waveform output register.
// Assumes: cnt, cnt_up and at_top come from the counter core of the same
// timer; force_strobe is a single-cycle pulse.
module dct_cmp_chan
    import dct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic         cnt_up,
    input  logic         at_top,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   act,
    input  logic         force_strobe,
    input  logic         flag_clr,
    output logic [W-1:0] ocr_act,
    output logic         wave,
    output logic         flag
);
    logic [W-1:0] ocr_shadow;
    logic         pwm;
    logic         match;
    logic         wave_nxt;
    cmp_act_e     ca;

    function automatic logic apply_act(input cmp_act_e a, input logic cur);
        unique case (a)
            ACT_TOG:  return ~cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

    // Decode mode and compare equality.
    always_comb begin
        pwm   = mode[1];
        match = (cnt == ocr_act);
        ca    = cmp_act_e'(act);
    end

    // Shadow register captures every write.
    always_ff @(posedge clk) begin
        if (!rst_n)  ocr_shadow <= '0;
        else if (wr) ocr_shadow <= wdata;
    end

    // Active compare: direct write outside PWM, shadow copy at top in PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ocr_act <= '0;
        else if (!pwm && wr)            ocr_act <= wdata;
        else if (pwm && tick && at_top) ocr_act <= ocr_shadow;
    end

    // Sticky match flag, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             flag <= 1'b0;
        else if (tick && match) flag <= 1'b1;
        else if (flag_clr)      flag <= 1'b0;
    end

    // Next waveform level for the selected mode.
    always_comb begin
        wave_nxt = wave;
        unique case (wave_mode_e'(mode))
            WM_FREE, WM_CLRA: begin
                if (force_strobe)       wave_nxt = apply_act(ca, wave);
                else if (tick && match) wave_nxt = apply_act(ca, wave);
            end
            WM_SLOPE: begin
                if (tick) begin
                    if (at_top) begin
                        if (ca == ACT_LOW)       wave_nxt = 1'b1;
                        else if (ca == ACT_HIGH) wave_nxt = 1'b0;
                    end else if (match) begin
                        if (ca == ACT_LOW)       wave_nxt = 1'b0;
                        else if (ca == ACT_HIGH) wave_nxt = 1'b1;
                    end
                end
            end
            WM_DUAL: begin
                if (tick && match) begin
                    if (ca == ACT_LOW)       wave_nxt = !cnt_up;
                    else if (ca == ACT_HIGH) wave_nxt = cnt_up;
                end
            end
            default: wave_nxt = wave;
        endcase
    end

    // Waveform register.
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else        wave <= wave_nxt;
    end
endmodule

// File: rtl/dual_cmp_timer.sv
`timescale 1ns/1ps
// Dual-compare timer top: count-source select, counter core and two
// compare channels built by a generate loop.
// Assumes: all inputs except ext_pin are synchronous to clk.
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   clk_sel,
    input  logic         pre_tick,
    input  logic         ext_pin,
    input  logic         ext_rise,
    input  logic [1:0]   mode,
    input  logic [1:0]   act_a,
    input  logic [1:0]   act_b,
    input  logic         cmp_a_wr,
    input  logic         cmp_b_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         force_a,
    input  logic         force_b,
    input  logic [2:0]   flag_clr,
    output logic [W-1:0] count,
    output logic         wave_a,
    output logic         wave_b,
    output logic         ovf_flag,
    output logic         match_a_flag,
    output logic         match_b_flag
);
    localparam int NCH = 2;

    logic           tick;
    logic           cnt_up;
    logic           at_top;
    logic [NCH-1:0] wr_v;
    logic [NCH-1:0] frc_v;
    logic [NCH-1:0] wave_v;
    logic [NCH-1:0] flag_v;
    logic [1:0]     act_v   [NCH];
    logic [W-1:0]   ocr_act [NCH];

    // Gather per-channel controls into vectors.
    always_comb begin
        wr_v     = {cmp_b_wr, cmp_a_wr};
        frc_v    = {force_b, force_a};
        act_v[0] = act_a;
        act_v[1] = act_b;
    end

    dct_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (clk_sel),
        .pre_tick (pre_tick),
        .ext_pin  (ext_pin),
        .ext_rise (ext_rise),
        .tick     (tick)
    );

    dct_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode),
        .ctc_top  (ocr_act[0]),
        .ovf_clr  (flag_clr[0]),
        .cnt      (count),
        .cnt_up   (cnt_up),
        .at_top   (at_top),
        .ovf_flag (ovf_flag)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dct_cmp_chan #(.W(W)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick         (tick),
            .mode         (mode),
            .cnt          (count),
            .cnt_up       (cnt_up),
            .at_top       (at_top),
            .wr           (wr_v[g]),
            .wdata        (cmp_wdata),
            .act          (act_v[g]),
            .force_strobe (frc_v[g]),
            .flag_clr     (flag_clr[g+1]),
            .ocr_act      (ocr_act[g]),
            .wave         (wave_v[g]),
            .flag         (flag_v[g])
        );
    end

    // Drive the per-channel outputs.
    always_comb begin
        wave_a       = wave_v[0];
        wave_b       = wave_v[1];
        match_a_flag = flag_v[0];
        match_b_flag = flag_v[1];
    end
endmodule

// File: rtl/dual_cmp_timer_chk.sv
`timescale 1ns/1ps
// Property checker for dual_cmp_timer, attached by bind.
// Assumes: the ocr_a / ocr_b ports see the active compare values.
module dual_cmp_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   clk_sel,
    input logic [1:0]   mode,
    input logic [1:0]   act_a,
    input logic         force_a,
    input logic [2:0]   flag_clr,
    input logic [W-1:0] count,
    input logic [W-1:0] ocr_a,
    input logic [W-1:0] ocr_b,
    input logic         wave_a,
    input logic         ovf_flag,
    input logic         match_b_flag
);
    localparam logic [W-1:0] MAXV = '1;

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b00) |=> (count == $past(count)));

    // R3
    normal_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && clk_sel == 2'b01 && count == MAXV) |=> (count == '0 && ovf_flag));

    // R4
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && clk_sel == 2'b01 && count == ocr_a) |=> (count == '0));

    // R6
    match_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b01 && count == ocr_b) |=> match_b_flag);

    // R8
    fast_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && clk_sel == 2'b01 && count == MAXV && act_a == 2'b10) |=> wave_a);

    // R9
    phase_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && clk_sel == 2'b01 && count == MAXV) |=> (count == MAXV - 1'b1));

    // R11
    force_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0 && clk_sel == 2'b00 && force_a && act_a == 2'b01)
        |=> (wave_a != $past(wave_a)));

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr[0]) |=> ovf_flag);
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel      (clk_sel),
    .mode         (mode),
    .act_a        (act_a),
    .force_a      (force_a),
    .flag_clr     (flag_clr),
    .count        (count),
    .ocr_a        (ocr_act[0]),
    .ocr_b        (ocr_act[1]),
    .wave_a       (wave_a),
    .ovf_flag     (ovf_flag),
    .match_b_flag (match_b_flag)
);

// File: tb/dual_cmp_timer_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps counts, compare values and modes, with
// expected values computed arithmetically.
module dual_cmp_timer_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] clk_sel, mode, act_a, act_b;
    logic       pre_tick, ext_pin, ext_rise;
    logic       cmp_a_wr, cmp_b_wr, force_a, force_b;
    logic [7:0] cmp_wdata;
    logic [2:0] flag_clr;
    logic [7:0] count;
    logic       wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .pre_tick(pre_tick),
        .ext_pin(ext_pin), .ext_rise(ext_rise), .mode(mode), .act_a(act_a),
        .act_b(act_b), .cmp_a_wr(cmp_a_wr), .cmp_b_wr(cmp_b_wr),
        .cmp_wdata(cmp_wdata), .force_a(force_a), .force_b(force_b),
        .flag_clr(flag_clr), .count(count), .wave_a(wave_a), .wave_b(wave_b),
        .ovf_flag(ovf_flag), .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clk_sel = 2'b00; mode = 2'b00; act_a = 2'b00; act_b = 2'b00;
        pre_tick = 1'b0; ext_pin = 1'b0; ext_rise = 1'b1; cmp_a_wr = 1'b0;
        cmp_b_wr = 1'b0; force_a = 1'b0; force_b = 1'b0; cmp_wdata = 8'd0;
        flag_clr = 3'b000;
        run(3);
        rst_n = 1'b1;
    endtask

    task automatic write_a(input int v);
        cmp_a_wr = 1'b1; cmp_wdata = 8'(v);
        @(negedge clk);
        cmp_a_wr = 1'b0;
    endtask

    task automatic write_b(input int v);
        cmp_b_wr = 1'b1; cmp_wdata = 8'(v);
        @(negedge clk);
        cmp_b_wr = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        while (count != 8'(v)) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ks [9] = '{1, 17, 200, 255, 256, 257, 511, 512, 600};
        int os [5] = '{0, 3, 77, 254, 255};
        int ns [4] = '{0, 3, 9, 40};
        int fs [6] = '{0, 1, 64, 127, 254, 255};
        int ps [4] = '{1, 50, 128, 254};
        int hi;
        int hib;
        int c0;

        // R1: reset state, also after activity
        do_reset();
        check_eq("R1 count", int'(count), 0);
        check_eq("R1 waves", int'({wave_a, wave_b}), 0);
        check_eq("R1 flags", int'({ovf_flag, match_a_flag, match_b_flag}), 0);
        clk_sel = 2'b01; act_a = 2'b01; run(300);
        do_reset();
        check_eq("R1 count after run", int'(count), 0);
        check_eq("R1 flags after run", int'({ovf_flag, match_a_flag, wave_a}), 0);

        // R2: stopped source holds the count
        run(20);
        check_eq("R2 stopped", int'(count), 0);

        // R3: free-running sweep
        foreach (ks[i]) begin
            do_reset();
            clk_sel = 2'b01;
            run(ks[i]);
            check_eq("R3 count", int'(count), ks[i] % 256);
            check_eq("R3 ovf", int'(ovf_flag), (ks[i] >= 256) ? 1 : 0);
        end

        // R6: match flag timing
        foreach (os[i]) begin
            for (int d = 0; d < 2; d++) begin
                do_reset();
                write_a(os[i]);
                clk_sel = 2'b01;
                run(os[i] + d);
                check_eq("R6 flag A", int'(match_a_flag), d);
            end
        end

        // R4 / R7: clear-on-compare with toggle
        foreach (ns[i]) begin
            for (int j = 0; j < 4; j++) begin
                int k;
                k = (j == 0) ? ns[i] : (j == 1) ? ns[i] + 1 : (j == 2) ? 3 * ns[i] + 5 : 100;
                do_reset();
                mode = 2'b01; act_a = 2'b01;
                write_a(ns[i]);
                clk_sel = 2'b01;
                run(k);
                check_eq("R4 ctc count", int'(count), k % (ns[i] + 1));
                check_eq("R7 ctc toggle", int'(wave_a), (k / (ns[i] + 1)) % 2);
            end
        end

        // R7: clear and set actions in free-running mode
        do_reset();
        act_a = 2'b11; act_b = 2'b10;
        write_a(10); write_b(20);
        clk_sel = 2'b01; run(11);
        check_eq("R7 set action", int'(wave_a), 1);
        act_b = 2'b01; run(10);
        check_eq("R7 toggle B", int'(wave_b), 1);
        act_b = 2'b10; run(256);
        check_eq("R7 clear action", int'(wave_b), 0);

        // R5: immediate write outside PWM
        do_reset();
        act_a = 2'b11;
        write_a(100);
        clk_sel = 2'b01;
        wait_cnt(50);
        check_eq("R5 before write", int'(wave_a), 0);
        write_a(60);
        wait_cnt(80);
        check_eq("R5 immediate", int'(wave_a), 1);

        // R5: shadowed write in single-slope PWM
        do_reset();
        mode = 2'b10; act_a = 2'b10;
        write_a(100);
        clk_sel = 2'b01;
        run(10);
        wait_cnt(0);
        wait_cnt(50);
        write_a(60);
        wait_cnt(80);
        check_eq("R5 old value held", int'(wave_a), 1);
        wait_cnt(110);
        check_eq("R5 old match", int'(wave_a), 0);
        wait_cnt(50);
        check_eq("R5 next period high", int'(wave_a), 1);
        wait_cnt(80);
        check_eq("R5 new value active", int'(wave_a), 0);

        // R8: single-slope duty sweep, both polarities
        foreach (fs[i]) begin
            do_reset();
            mode = 2'b10; act_a = 2'b10; act_b = 2'b11;
            write_a(fs[i]); write_b(fs[i]);
            clk_sel = 2'b01;
            run(300);
            wait_cnt(0);
            hi = 0; hib = 0;
            for (int s = 0; s < 256; s++) begin
                hi += int'(wave_a); hib += int'(wave_b);
                @(negedge clk);
            end
            check_eq("R8 duty A", hi, (fs[i] == 255) ? 256 : fs[i] + 1);
            check_eq("R8 duty B", hib, (fs[i] == 255) ? 0 : 255 - fs[i]);
        end

        // R9 / R10: dual-slope duty and bottom-only overflow
        foreach (ps[i]) begin
            do_reset();
            mode = 2'b11; act_a = 2'b10; act_b = 2'b11;
            write_a(ps[i]); write_b(ps[i]);
            clk_sel = 2'b01;
            run(600);
            wait_cnt(0);
            hi = 0; hib = 0; c0 = 0;
            for (int s = 0; s < 510; s++) begin
                flag_clr = (s == 0) ? 3'b001 : 3'b000;
                hi += int'(wave_a); hib += int'(wave_b);
                if (count == 8'd0) c0++;
                if (s == 255) begin
                    check_eq("R9 peak count", int'(count), 255);
                    check_eq("R9 no ovf at top", int'(ovf_flag), 0);
                end
                if (s == 509) begin
                    check_eq("R9 descend", int'(count), 1);
                    check_eq("R9 no ovf yet", int'(ovf_flag), 0);
                end
                @(negedge clk);
            end
            check_eq("R9 bottom once", c0, 1);
            check_eq("R9 bottom reached", int'(count), 0);
            check_eq("R9 ovf at bottom", int'(ovf_flag), 1);
            check_eq("R10 duty A", hi, 2 * ps[i]);
            check_eq("R10 duty B", hib, 510 - 2 * ps[i]);
        end

        // R11: force strobes
        do_reset();
        act_a = 2'b01; act_b = 2'b11;
        write_a(200); write_b(200);
        clk_sel = 2'b01; run(20); clk_sel = 2'b00;
        force_a = 1'b1; force_b = 1'b1; @(negedge clk); force_a = 1'b0; force_b = 1'b0;
        check_eq("R11 force A", int'(wave_a), 1);
        check_eq("R11 force B", int'(wave_b), 1);
        check_eq("R11 no flag", int'({match_a_flag, match_b_flag}), 0);
        check_eq("R11 count kept", int'(count), 20);
        mode = 2'b01;
        force_a = 1'b1; @(negedge clk); force_a = 1'b0;
        check_eq("R11 force in ctc", int'(wave_a), 0);
        check_eq("R11 ctc count kept", int'(count), 20);
        mode = 2'b10;
        force_a = 1'b1; @(negedge clk); force_a = 1'b0;
        check_eq("R11 ignored slope", int'(wave_a), 0);
        mode = 2'b11;
        force_a = 1'b1; @(negedge clk); force_a = 1'b0;
        check_eq("R11 ignored dual", int'(wave_a), 0);

        // R12: write-one-to-clear and set priority
        do_reset();
        write_a(5); write_b(7);
        clk_sel = 2'b01; run(10); clk_sel = 2'b00;
        flag_clr = 3'b010; @(negedge clk); flag_clr = 3'b000;
        check_eq("R12 clear A", int'(match_a_flag), 0);
        check_eq("R12 B kept", int'(match_b_flag), 1);
        flag_clr = 3'b100; @(negedge clk); flag_clr = 3'b000;
        check_eq("R12 clear B", int'(match_b_flag), 0);
        do_reset();
        write_a(5);
        clk_sel = 2'b01; run(5); clk_sel = 2'b00;
        check_eq("R12 not yet set", int'(match_a_flag), 0);
        clk_sel = 2'b01; flag_clr = 3'b010; @(negedge clk);
        clk_sel = 2'b00; flag_clr = 3'b000;
        check_eq("R12 set wins", int'(match_a_flag), 1);

        // R2: prescaler tick and event pin edges
        do_reset();
        clk_sel = 2'b10;
        for (int p = 0; p < 7; p++) begin
            pre_tick = 1'b1; @(negedge clk); pre_tick = 1'b0; run(2);
        end
        check_eq("R2 prescale", int'(count), 7);
        for (int e = 0; e < 2; e++) begin
            do_reset();
            clk_sel = 2'b11; ext_rise = (e == 0);
            for (int p = 0; p < 5; p++) begin
                ext_pin = 1'b1; run(4);
                if (p < 4) begin ext_pin = 1'b0; run(4); end
            end
            run(4);
            check_eq(e == 0 ? "R2 pin rising" : "R2 pin falling", int'(count), e == 0 ? 5 : 4);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule